// File: doc/BRIEF.md
# Partitioned March Memory Self-Test Engine

This block is a built-in self-test sequencer for a single-port RAM of 2^ADDR_W words, each DATA_W bits wide. It finds stuck bits, inversion coupling between cells, address-decoder aliasing and faults that depend on the contents of nearby cells. The address space is split into NUM_SETS interleaved partitions. Set k holds every address whose value modulo NUM_SETS equals k, so two cells of one set are always at least NUM_SETS words apart.

The sets are tested one after another, in ascending order. For each set, the engine first writes a fixed background word to every cell outside the set. It then runs a four-element march over the cells of the set. Last, it reads back every cell outside the set to confirm the background is intact. With NUM_SETS equal to 1 this is a plain march over the whole array. With NUM_SETS equal to the word count, every cell is exercised alone against a fixed background, as in a walking test.

A one-cycle start pulse launches a run. The engine stops at the first wrong read, or after the last set, and reports through done, fail and the failing address. The RAM port has a one-cycle synchronous read.

Top module: `pm_march_bist`

## Requirements
- R1: While reset is held and after it is released, busy, done, fail and mem_we are all low until a start is seen.
- R2: When start is sampled high while the engine is not busy, busy is high from the next cycle. A start that arrives while busy has no effect and does not change the length of the run. busy and done are never high together.
- R3: Set k (k = addr mod NUM_SETS) is processed for k = 0 up to NUM_SETS-1. During a set's march, only addresses of that set are presented.
- R4: Before a set's march, every address outside the set is written with the background word. In the background word, bit i is 1 for odd i and 0 for even i, which is 8'hAA for 8 bits. After the march, every address outside the set is read back. A background cell that was disturbed (for example by a write coupled in from the set under test) is reported as a failure.
- R5: The march over a set runs four elements in this order. (a) In ascending address order, write all zeros. (b) In ascending order, read and expect all zeros, then write all ones. (c) In descending order, read and expect all ones, then write all zeros. (d) In ascending order, read and expect all zeros.
- R6: On the first read that differs from its expected word, fail goes high, fail_addr holds the address that was read, and done goes high. No write occurs after that point, or at any time while busy is low.
- R7: done, fail and fail_addr keep their values until the next start. The next start clears fail and done.
- R8: A read presents the address with mem_we low. The engine compares mem_rdata in the following cycle, which is the RAM's one-cycle read latency.
- R9: A run on a fault-free RAM ends with done high and fail low. After the run, cells of the last set hold zeros and every other cell holds the background word.
- R10: The engine reports each of these at the address that the R3 to R5 order first reads wrong: a bit stuck at 0 or 1, a write to one cell that inverts another, and a decoder fault in which a write to one address also lands on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when not busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DATA_W | RAM read data, one cycle after address |

## Verification
The hardest case to reach is a failure in the background check. Here the set under test is read correctly, but a write inside it has silently changed a cell of another set. That wrong value only shows up in the read-back after the march.

The bench's RAM model injects such cross-set inversion coupling and decoder aliasing, along with stuck bits and same-set coupling, at chosen and at random addresses. A transaction-level model of the sequence runs on a second copy of the same faulty memory and predicts which address is read wrong first.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } eng_st_e;

    typedef enum logic [2:0] {
        PH_BG_FILL,
        PH_ZERO_FILL,
        PH_UP_R0W1,
        PH_DN_R1W0,
        PH_UP_R0,
        PH_BG_VERIFY
    } phase_e;

endpackage

// File: rtl/pm_set_geom.sv
module pm_set_geom #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned SET_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SET_W-1:0]  set_idx,
    output logic              in_set,
    output logic              at_low,
    output logic              at_high,
    output logic [ADDR_W-1:0] low_addr,
    output logic [ADDR_W-1:0] high_addr,
    output logic [ADDR_W-1:0] up_addr,
    output logic [ADDR_W-1:0] dn_addr
);
    localparam logic [31:0] WORDS = 32'(1) << ADDR_W;
    localparam logic [31:0] STEP  = 32'(NUM_SETS);

    logic [31:0] a32, s32, hi32;

    always_comb begin
        a32       = 32'(addr);
        s32       = 32'(set_idx);
        // Highest address congruent to the set index.
        hi32      = s32 + ((WORDS - 32'd1 - s32) / STEP) * STEP;
        in_set    = (a32 % STEP) == s32;
        low_addr  = ADDR_W'(s32);
        high_addr = ADDR_W'(hi32);
        at_low    = (addr == low_addr);
        at_high   = (addr == high_addr);
        up_addr   = ADDR_W'(a32 + STEP);
        dn_addr   = ADDR_W'(a32 - STEP);
    end

endmodule

// File: rtl/pm_pattern.sv
module pm_pattern
    import pm_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  phase_e             ph,
    input  logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  wdata,
    output logic               mismatch
);
    function automatic logic [DATA_W-1:0] bg_word();
        logic [DATA_W-1:0] w;
        for (int j = 0; j < int'(DATA_W); j++) begin
            w[j] = ((j % 2) == 1);
        end
        return w;
    endfunction

    localparam logic [DATA_W-1:0] BG = bg_word();

    logic [DATA_W-1:0] expect_w;

    always_comb begin
        unique case (ph)
            PH_BG_FILL:   wdata = BG;
            PH_UP_R0W1:   wdata = '1;
            default:      wdata = '0;
        endcase
        unique case (ph)
            PH_DN_R1W0:   expect_w = '1;
            PH_BG_VERIFY: expect_w = BG;
            default:      expect_w = '0;
        endcase
        mismatch = (rdata != expect_w);
    end

endmodule

// File: rtl/pm_march_bist.sv
module pm_march_bist
    import pm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_SETS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned       SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam logic [SET_W-1:0]  LAST_SET = SET_W'(NUM_SETS - 1);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    typedef struct packed {
        eng_st_e           st;
        phase_e            ph;
        logic              chk;
        logic [ADDR_W-1:0] addr;
        logic [SET_W-1:0]  set;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } eng_t;

    eng_t s_d, s_q;

    logic              in_set, at_low, at_high, mismatch;
    logic [ADDR_W-1:0] low_addr, high_addr, up_addr, dn_addr;
    logic              we_c, bg_step;

    pm_set_geom #(
        .ADDR_W  (ADDR_W),
        .NUM_SETS(NUM_SETS),
        .SET_W   (SET_W)
    ) u_geom (
        .addr     (s_q.addr),
        .set_idx  (s_q.set),
        .in_set   (in_set),
        .at_low   (at_low),
        .at_high  (at_high),
        .low_addr (low_addr),
        .high_addr(high_addr),
        .up_addr  (up_addr),
        .dn_addr  (dn_addr)
    );

    pm_pattern #(
        .DATA_W(DATA_W)
    ) u_pat (
        .ph      (s_q.ph),
        .rdata   (mem_rdata),
        .wdata   (mem_wdata),
        .mismatch(mismatch)
    );

    always_comb begin
        s_d     = s_q;
        we_c    = 1'b0;
        bg_step = 1'b0;
        unique case (s_q.st)
            ST_RUN: begin
                unique case (s_q.ph)
                    PH_BG_FILL: begin
                        we_c = !in_set;
                        if (s_q.addr == ADDR_MAX) begin
                            s_d.ph   = PH_ZERO_FILL;
                            s_d.addr = low_addr;
                        end else begin
                            s_d.addr = s_q.addr + 1'b1;
                        end
                    end
                    PH_ZERO_FILL: begin
                        we_c = 1'b1;
                        if (at_high) begin
                            s_d.ph   = PH_UP_R0W1;
                            s_d.addr = low_addr;
                        end else begin
                            s_d.addr = up_addr;
                        end
                    end
                    PH_UP_R0W1, PH_DN_R1W0, PH_UP_R0: begin
                        s_d.chk = !s_q.chk;
                        if (s_q.chk) begin
                            if (mismatch) begin
                                s_d.st        = ST_DONE;
                                s_d.fail      = 1'b1;
                                s_d.fail_addr = s_q.addr;
                            end else begin
                                we_c = (s_q.ph != PH_UP_R0);
                                if (s_q.ph == PH_DN_R1W0) begin
                                    if (at_low) begin
                                        s_d.ph   = PH_UP_R0;
                                        s_d.addr = low_addr;
                                    end else begin
                                        s_d.addr = dn_addr;
                                    end
                                end else if (!at_high) begin
                                    s_d.addr = up_addr;
                                end else if (s_q.ph == PH_UP_R0W1) begin
                                    s_d.ph   = PH_DN_R1W0;
                                    s_d.addr = high_addr;
                                end else begin
                                    s_d.ph   = PH_BG_VERIFY;
                                    s_d.addr = '0;
                                end
                            end
                        end
                    end
                    PH_BG_VERIFY: begin
                        if (!s_q.chk) begin
                            if (in_set) bg_step = 1'b1;
                            else        s_d.chk = 1'b1;
                        end else begin
                            s_d.chk = 1'b0;
                            if (mismatch) begin
                                s_d.st        = ST_DONE;
                                s_d.fail      = 1'b1;
                                s_d.fail_addr = s_q.addr;
                            end else begin
                                bg_step = 1'b1;
                            end
                        end
                        if (bg_step) begin
                            if (s_q.addr != ADDR_MAX) begin
                                s_d.addr = s_q.addr + 1'b1;
                            end else if (s_q.set == LAST_SET) begin
                                s_d.st = ST_DONE;
                            end else begin
                                s_d.set  = s_q.set + 1'b1;
                                s_d.ph   = PH_BG_FILL;
                                s_d.addr = '0;
                            end
                        end
                    end
                    default: s_d.st = ST_IDLE;
                endcase
            end
            default: begin
                if (start) begin
                    s_d.st        = ST_RUN;
                    s_d.ph        = PH_BG_FILL;
                    s_d.chk       = 1'b0;
                    s_d.addr      = '0;
                    s_d.set       = '0;
                    s_d.fail      = 1'b0;
                    s_d.fail_addr = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ph: PH_BG_FILL, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st == ST_RUN);
    assign done      = (s_q.st == ST_DONE);
    assign fail      = s_q.fail;
    assign fail_addr = s_q.fail_addr;
    assign mem_addr  = s_q.addr;
    assign mem_we    = we_c;

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R6
    AST_FAIL_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R6
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R2
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_addr))); // R7
    AST_MARCH_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (s_q.ph inside {PH_ZERO_FILL, PH_UP_R0W1, PH_DN_R1W0, PH_UP_R0}))
        |-> in_set); // R3

endmodule

// File: tb/pm_march_bist_tb.sv
module pm_march_bist_tb;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NS = 2;
    localparam int NW = 1 << AW;
    localparam logic [DW-1:0] BG = 8'hAA;

    logic          clk = 1'b0;
    logic          rst_n, start;
    logic          busy, done, fail, mem_we;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    pm_march_bist #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    int unsigned n_chk = 0, n_bad = 0, stray_we = 0;
    // fault kinds: 0 none, 1 stuck0, 2 stuck1, 3 inversion coupling, 4 decoder alias
    int ft = 0, fa = 0, fv = 0, fb = 0;
    logic [DW-1:0] mem [2][NW];

    function automatic logic [DW-1:0] mread(int w, int a);
        logic [DW-1:0] v;
        v = mem[w][a];
        if (ft == 1 && a == fa) v[fb] = 1'b0;
        if (ft == 2 && a == fa) v[fb] = 1'b1;
        return v;
    endfunction

    task automatic mwrite(int w, int a, logic [DW-1:0] d);
        mem[w][a] = d;
        if (ft == 3 && a == fa) mem[w][fv] = ~mem[w][fv];
        if (ft == 4 && a == fa) mem[w][fv] = d;
    endtask

    always @(posedge clk) begin
        mem_rdata <= mread(0, int'(mem_addr));
        if (mem_we) mwrite(0, int'(mem_addr), mem_wdata);
        if (mem_we && !busy) stray_we++;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Transaction-level model of the test order, run on copy 1.
    task automatic predict(output bit found, output int fad);
        found = 0; fad = 0;
        for (int k = 0; k < NS; k++) begin
            int top;
            top = k;
            for (int a = 0; a < NW; a++) if (a % NS != k) mwrite(1, a, BG);
            for (int a = k; a < NW; a += NS) begin mwrite(1, a, '0); top = a; end
            for (int a = k; a < NW; a += NS) begin
                if (mread(1, a) != '0) begin found = 1; fad = a; return; end
                mwrite(1, a, '1);
            end
            for (int a = top; a >= k; a -= NS) begin
                if (mread(1, a) != '1) begin found = 1; fad = a; return; end
                mwrite(1, a, '0);
            end
            for (int a = k; a < NW; a += NS)
                if (mread(1, a) != '0) begin found = 1; fad = a; return; end
            for (int a = 0; a < NW; a++)
                if (a % NS != k && mread(1, a) != BG) begin found = 1; fad = a; return; end
        end
    endtask

    int last_len = 0;

    task automatic run_case(int t, int a, int v, int b, string req, int mid_start);
        bit ef; int ea; int cyc;
        ft = t; fa = a; fv = v; fb = b;
        for (int i = 0; i < NW; i++) begin mem[0][i] = '0; mem[1][i] = '0; end
        predict(ef, ea);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R2", "busy after start", int'(busy), 1);
        cyc = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (mid_start != 0 && cyc == mid_start) start = 1'b1;
            else start = 1'b0;
        end
        last_len = cyc;
        check(done === 1'b1, "R6", "done reached", int'(done), 1);
        check(fail === ef, req, "fail flag", int'(fail), int'(ef));
        if (ef) check(int'(fail_addr) == ea, req, "fail address", int'(fail_addr), ea);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int clean_len;
        logic [AW-1:0] held;
        int bad_cells;
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "outputs in reset", int'({busy, done, fail, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "idle after reset", int'({busy, done, fail, mem_we}), 0);

        // Clean run: R8 read latency and R9 end state
        run_case(0, 0, 0, 0, "R8", 0);
        clean_len = last_len;
        bad_cells = 0;
        for (int a = 0; a < NW; a++) begin
            logic [DW-1:0] e;
            e = (a % NS == NS - 1) ? '0 : BG;
            if (mem[0][a] !== e) bad_cells++;
        end
        check(bad_cells == 0, "R9", "final contents", bad_cells, 0);
        repeat (5) @(negedge clk);
        check(done && !fail, "R7", "clean result held", int'({done, fail}), 2);

        // Start while busy is ignored: same length
        run_case(0, 0, 0, 0, "R2", 40);
        check(last_len == clean_len, "R2", "run length with mid start", last_len, clean_len);

        // Stuck bits
        run_case(1, 5, 0, 1, "R10", 0);
        check(fail_addr == 5, "R10", "stuck0 odd address", int'(fail_addr), 5);
        run_case(2, 12, 0, 3, "R10", 0);
        check(fail_addr == 12, "R10", "stuck1 even address", int'(fail_addr), 12);
        // Cross-set coupling caught only by background verify
        run_case(3, 2, 3, 0, "R4", 0);
        check(fail_addr == 3, "R4", "background disturbed", int'(fail_addr), 3);
        // Same-set coupling caught by march order
        run_case(3, 4, 2, 0, "R5", 0);
        check(fail_addr == 2, "R5", "march order coupling", int'(fail_addr), 2);
        run_case(3, 2, 4, 0, "R5", 0);
        check(fail_addr == 4, "R3", "same-set victim", int'(fail_addr), 4);
        // Decoder alias
        run_case(4, 10, 11, 0, "R10", 0);
        check(fail_addr == 11, "R10", "decoder alias", int'(fail_addr), 11);
        // Top-address corner
        run_case(1, NW - 1, 0, 7, "R10", 0);

        // Hold and clear
        held = fail_addr;
        repeat (6) @(negedge clk);
        check(done && fail && fail_addr == held, "R7", "fail held", int'(fail_addr), int'(held));
        ft = 0;
        for (int i = 0; i < NW; i++) mem[0][i] = '0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!fail && !done && busy, "R7", "start clears result", int'({fail, done}), 0);
        while (!done) @(negedge clk);

        // Random faults
        for (int i = 0; i < 24; i++) begin
            int t, a, v, b;
            t = 1 + int'($urandom % 4);
            a = int'($urandom % NW);
            v = (a + 1 + int'($urandom % (NW - 1))) % NW;
            b = int'($urandom % DW);
            run_case(t, a, v, b, "R10", 0);
        end

        check(stray_we == 0, "R6", "writes while not busy", int'(stray_we), 0);
        summary();
        $finish;
    end

endmodule